// File: doc/BRIEF.md
# Interrupt distributor register bank

This block holds the per-interrupt state of a small interrupt controller: one enable bit, one pending bit, one active bit, an 8-bit priority, an 8-bit target byte and a trigger selection for each of 64 interrupt lines. Software reaches all of it through a simple 32-bit word bus with a combinational read port. Raw interrupt lines come in directly. Each line is either latched on a rising edge or followed as a level, as its trigger selection says.

From the enabled, pending and not-yet-active interrupts, the block picks one winner and presents it to a single CPU interface. The CPU interface answers with an acknowledge pulse, which takes the winner, and later with an end-of-interrupt pulse, which names the interrupt to retire. Enable and pending state change through paired set and clear windows with write-one semantics, so software never needs a read-modify-write.

Top module: `irq_dist`

## Requirements
- R1: Bit 0 of the control word at offset 0x000 gates forwarding. While it is 0, sel_valid stays low. It reads back in bit 0.
- R2: The read-only word at 0x004 returns (lines/32 − 1) in bits [4:0] and (CPU count − 1) in bits [7:5]. With the defaults it reads 0x00000001.
- R3: Enable state is set through 0x100 and cleared through 0x180. Bit b of word w stands for ID 32·w+b. A 1 acts on its bit and a 0 leaves it unchanged. Both windows read back the current enables.
- R4: Latched pending state is set through 0x200 and cleared through 0x280, using the same bit layout and write-one rule. Both windows read the effective pending state. For a level line, the effective state is the input itself.
- R5: Priority bytes start at 0x400 and target bytes start at 0x800. ID n occupies bits [8·(n%4)+7 : 8·(n%4)] of word n/4. Target bytes are storage only and never change the selection.
- R6: Trigger words start at 0xC00. ID n uses bit 2·(n%16)+1 of word n/16, where 1 means edge and 0 means level. The even bits read 0. IDs below 32 always read as edge and ignore writes.
- R7: An edge line becomes pending in the cycle after its input rises, and stays pending until it is cleared by software or by acknowledge. A level line counts as pending in the same cycle that its input is high.
- R8: The output is the enabled, pending, non-active interrupt with the lowest priority value, with ties going to the lowest ID. It is combinational on the current state and the inputs.
- R9: An acknowledge while sel_valid is high makes sel_id active and clears its latched pending bit. An end-of-interrupt clears the active bit of eoi_id. If both name the same ID in one cycle, the acknowledge wins.
- R10: Unimplemented offsets (for example 0x008, 0x108 and 0x300) read 0, and writes to them change nothing.
- R11: After reset, every enable, pending, active, priority and target bit is 0 and control is 0. IDs 0–31 are edge, and IDs 32 and above are level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the word at bus_addr |
| bus_addr | input | 12 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_in | input | 64 | Raw interrupt lines |
| ack | input | 1 | Acknowledge of the presented interrupt |
| eoi | input | 1 | End-of-interrupt strobe |
| eoi_id | input | 6 | ID to retire on eoi |
| sel_valid | output | 1 | A winner is presented |
| sel_id | output | 6 | ID of the winner |
| sel_prio | output | 8 | Priority of the winner |

## Verification
The properties assume three things about the inputs. Addresses are word aligned. Only one bus write occurs per cycle. An acknowledge is counted only while a winner is presented. The end-of-interrupt property also excludes the cycle in which the same ID is acknowledged, because the acknowledge wins there. The stimulus only produces aligned addresses inside or just beyond each window, keeps eoi_id below the line count, and raises ack freely because the design ignores an acknowledge when no winner is presented.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;

    typedef enum logic [3:0] {
        RG_NONE, RG_CTRL, RG_TYPE, RG_SETEN, RG_CLREN,
        RG_SETPD, RG_CLRPD, RG_PRIO, RG_TGT, RG_CFG
    } region_e;

    // Region decode of a byte address; misaligned addresses hit nothing.
    function automatic region_e decode_region(input logic [11:0] a);
        region_e r;
        r = RG_NONE;
        if (a[1:0] == 2'b00) begin
            if (a[11:2] == 10'd0)           r = RG_CTRL;
            else if (a[11:2] == 10'd1)      r = RG_TYPE;
            else if (a[11:7] == 5'h02)      r = RG_SETEN;
            else if (a[11:7] == 5'h03)      r = RG_CLREN;
            else if (a[11:7] == 5'h04)      r = RG_SETPD;
            else if (a[11:7] == 5'h05)      r = RG_CLRPD;
            else if (a[11:10] == 2'b01)     r = RG_PRIO;
            else if (a[11:10] == 2'b10)     r = RG_TGT;
            else if (a[11:8] == 4'hC)       r = RG_CFG;
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_dist_edge.sv
module irq_dist_edge #(
    parameter int N = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl;
        rise   = lvl & ~prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/irq_dist_pick.sv
module irq_dist_pick #(
    parameter int N    = 64,
    parameter int PW   = 8,
    localparam int IDW = $clog2(N)
) (
    input  logic [N-1:0]    cand,
    input  logic [N*PW-1:0] prio,
    output logic            valid,
    output logic [IDW-1:0]  id,
    output logic [PW-1:0]   best
);
    // Strict less-than in ascending ID order keeps the lowest ID on ties.
    always_comb begin
        valid = 1'b0;
        id    = '0;
        best  = '0;
        for (int i = 0; i < N; i++) begin
            if (cand[i] && (!valid || prio[i*PW +: PW] < best)) begin
                valid = 1'b1;
                id    = IDW'(i);
                best  = prio[i*PW +: PW];
            end
        end
    end
endmodule

// File: rtl/irq_dist.sv
module irq_dist
    import irq_dist_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int NUM_CPU = 1,
    localparam int ID_W   = $clog2(NUM_IRQ)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [11:0]        bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic               ack,
    input  logic               eoi,
    input  logic [ID_W-1:0]    eoi_id,
    output logic               sel_valid,
    output logic [ID_W-1:0]    sel_id,
    output logic [7:0]         sel_prio
);
    localparam int NWORD     = NUM_IRQ / 32;
    localparam int PWORD     = NUM_IRQ / 4;
    localparam int CWORD     = NUM_IRQ / 16;
    localparam int FIRST_SPI = 32;

    typedef struct packed {
        logic                 ctrl_en;
        logic [NUM_IRQ-1:0]   en;
        logic [NUM_IRQ-1:0]   pend;
        logic [NUM_IRQ-1:0]   act;
        logic [NUM_IRQ-1:0]   edge_cfg;
        logic [NUM_IRQ*8-1:0] prio;
        logic [NUM_IRQ*8-1:0] tgt;
    } st_t;

    function automatic st_t st_reset();
        st_t s;
        s = '0;
        for (int i = 0; i < NUM_IRQ; i++) s.edge_cfg[i] = (i < FIRST_SPI);
        return s;
    endfunction

    st_t st_d, st_q;
    region_e rg;
    logic [4:0] wi;
    logic [7:0] pi;
    logic [5:0] ci;
    logic [NUM_IRQ-1:0] wmask, set_pd, clr_pd, ackm, eoim, rise, eff_pend, cand;

    // Signals brought out for the bound checker.
    logic               chk_ctrl_en;
    logic [NUM_IRQ-1:0] chk_en, chk_act;

    assign rg = decode_region(bus_addr);
    assign wi = bus_addr[6:2];
    assign pi = bus_addr[9:2];
    assign ci = bus_addr[7:2];

    irq_dist_edge #(.N(NUM_IRQ)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (irq_in),
        .rise (rise)
    );

    assign eff_pend = (st_q.edge_cfg & st_q.pend) | (~st_q.edge_cfg & irq_in);
    assign cand     = eff_pend & st_q.en & ~st_q.act & {NUM_IRQ{st_q.ctrl_en}};

    irq_dist_pick #(.N(NUM_IRQ), .PW(8)) u_pick (
        .cand (cand),
        .prio (st_q.prio),
        .valid(sel_valid),
        .id   (sel_id),
        .best (sel_prio)
    );

    // Next-state process.
    always_comb begin
        st_d   = st_q;
        wmask  = '0;
        set_pd = '0;
        clr_pd = '0;
        for (int w = 0; w < NWORD; w++)
            if (int'(wi) == w) wmask[w*32 +: 32] = bus_wdata;
        if (bus_wr) begin
            case (rg)
                RG_CTRL:  st_d.ctrl_en = bus_wdata[0];
                RG_SETEN: st_d.en = st_q.en | wmask;
                RG_CLREN: st_d.en = st_q.en & ~wmask;
                RG_SETPD: set_pd = wmask;
                RG_CLRPD: clr_pd = wmask;
                RG_PRIO: begin
                    for (int w = 0; w < PWORD; w++)
                        if (int'(pi) == w) st_d.prio[w*32 +: 32] = bus_wdata;
                end
                RG_TGT: begin
                    for (int w = 0; w < PWORD; w++)
                        if (int'(pi) == w) st_d.tgt[w*32 +: 32] = bus_wdata;
                end
                RG_CFG: begin
                    for (int c = FIRST_SPI / 16; c < CWORD; c++)
                        if (int'(ci) == c)
                            for (int k = 0; k < 16; k++)
                                st_d.edge_cfg[c*16 + k] = bus_wdata[2*k + 1];
                end
                default: ;
            endcase
        end
        ackm = '0;
        if (ack && sel_valid) ackm[sel_id] = 1'b1;
        eoim = '0;
        if (eoi) eoim[eoi_id] = 1'b1;
        st_d.pend = ((st_q.pend & ~clr_pd & ~ackm) | set_pd | rise) & st_q.edge_cfg;
        st_d.act  = (st_q.act & ~eoim) | ackm;
    end

    // Read mux.
    always_comb begin
        bus_rdata = '0;
        case (rg)
            RG_CTRL: bus_rdata[0] = st_q.ctrl_en;
            RG_TYPE: begin
                bus_rdata[4:0] = 5'(NWORD - 1);
                bus_rdata[7:5] = 3'(NUM_CPU - 1);
            end
            RG_SETEN, RG_CLREN: begin
                for (int w = 0; w < NWORD; w++)
                    if (int'(wi) == w) bus_rdata = st_q.en[w*32 +: 32];
            end
            RG_SETPD, RG_CLRPD: begin
                for (int w = 0; w < NWORD; w++)
                    if (int'(wi) == w) bus_rdata = eff_pend[w*32 +: 32];
            end
            RG_PRIO: begin
                for (int w = 0; w < PWORD; w++)
                    if (int'(pi) == w) bus_rdata = st_q.prio[w*32 +: 32];
            end
            RG_TGT: begin
                for (int w = 0; w < PWORD; w++)
                    if (int'(pi) == w) bus_rdata = st_q.tgt[w*32 +: 32];
            end
            RG_CFG: begin
                for (int c = 0; c < CWORD; c++)
                    if (int'(ci) == c)
                        for (int k = 0; k < 16; k++)
                            bus_rdata[2*k + 1] = st_q.edge_cfg[c*16 + k];
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= st_reset();
        else        st_q <= st_d;
    end

    assign chk_ctrl_en = st_q.ctrl_en;
    assign chk_en      = st_q.en;
    assign chk_act     = st_q.act;
endmodule

// File: rtl/irq_dist_chk.sv
module irq_dist_chk #(
    parameter int NUM_IRQ = 64,
    localparam int ID_W   = $clog2(NUM_IRQ)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr,
    input logic [11:0]        bus_addr,
    input logic [31:0]        bus_wdata,
    input logic               ack,
    input logic               eoi,
    input logic [ID_W-1:0]    eoi_id,
    input logic               sel_valid,
    input logic [ID_W-1:0]    sel_id,
    input logic               ctrl_en,
    input logic [NUM_IRQ-1:0] en,
    input logic [NUM_IRQ-1:0] act
);
    a_r1_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> ctrl_en);

    a_r8_winner_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> (en[sel_id] && !act[sel_id]));

    a_r9_ack_sets_active: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && sel_valid) |=> act[$past(sel_id)]);

    a_r9_eoi_retires: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && !(ack && sel_valid && sel_id == eoi_id)) |=> !act[$past(eoi_id)]);

    a_r3_clear_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 12'h180 && bus_wdata[0]) |=> !en[0]);
endmodule

bind irq_dist irq_dist_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .ack      (ack),
    .eoi      (eoi),
    .eoi_id   (eoi_id),
    .sel_valid(sel_valid),
    .sel_id   (sel_id),
    .ctrl_en  (chk_ctrl_en),
    .en       (chk_en),
    .act      (chk_act)
);

// File: tb/sim_irq_dist.sv
`timescale 1ns/1ps
module sim_irq_dist;
    localparam int N = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [N-1:0] irq_in = '0;
    logic        ack = 1'b0;
    logic        eoi = 1'b0;
    logic [5:0]  eoi_id = '0;
    logic        sel_valid;
    logic [5:0]  sel_id;
    logic [7:0]  sel_prio;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    irq_dist u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
        .ack(ack), .eoi(eoi), .eoi_id(eoi_id), .sel_valid(sel_valid),
        .sel_id(sel_id), .sel_prio(sel_prio)
    );

    // Reference state built from the requirements.
    bit [N-1:0] m_en, m_pend, m_act, m_edge, m_prev;
    bit [7:0]   m_prio [N];
    bit [7:0]   m_tgt  [N];
    bit         m_ctrl;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act_v,
                       input logic [31:0] exp_v);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act_v, exp_v);
        end
    endtask

    function automatic void m_reset();
        m_en = '0; m_pend = '0; m_act = '0; m_prev = '0; m_ctrl = 1'b0;
        for (int i = 0; i < N; i++) begin
            m_prio[i] = '0; m_tgt[i] = '0; m_edge[i] = (i < 32);
        end
    endfunction

    function automatic bit [N-1:0] m_eff();
        return (m_edge & m_pend) | (~m_edge & irq_in);
    endfunction

    function automatic void m_pick(output bit v, output int id, output bit [7:0] p);
        bit [N-1:0] c;
        c = m_eff() & m_en & ~m_act & {N{m_ctrl}};
        v = 0; id = 0; p = 0;
        for (int i = 0; i < N; i++)
            if (c[i] && (!v || m_prio[i] < p)) begin v = 1; id = i; p = m_prio[i]; end
    endfunction

    function automatic bit [31:0] m_read(bit [11:0] a);
        bit [31:0] r;
        bit [N-1:0] e;
        int w;
        r = '0;
        e = m_eff();
        if (a == 12'h000) r[0] = m_ctrl;
        else if (a == 12'h004) r = 32'h1;
        else if (a >= 12'h100 && a < 12'h108) begin w = (a - 12'h100) >> 2; r = m_en[w*32 +: 32]; end
        else if (a >= 12'h180 && a < 12'h188) begin w = (a - 12'h180) >> 2; r = m_en[w*32 +: 32]; end
        else if (a >= 12'h200 && a < 12'h208) begin w = (a - 12'h200) >> 2; r = e[w*32 +: 32]; end
        else if (a >= 12'h280 && a < 12'h288) begin w = (a - 12'h280) >> 2; r = e[w*32 +: 32]; end
        else if (a >= 12'h400 && a < 12'h440) begin
            w = (a - 12'h400) >> 2;
            for (int k = 0; k < 4; k++) r[8*k +: 8] = m_prio[4*w + k];
        end
        else if (a >= 12'h800 && a < 12'h840) begin
            w = (a - 12'h800) >> 2;
            for (int k = 0; k < 4; k++) r[8*k +: 8] = m_tgt[4*w + k];
        end
        else if (a >= 12'hC00 && a < 12'hC10) begin
            w = (a - 12'hC00) >> 2;
            for (int k = 0; k < 16; k++) r[2*k + 1] = m_edge[16*w + k];
        end
        return r;
    endfunction

    function automatic string rtag(bit [11:0] a);
        if (a < 12'h100) return "R2/R1 read";
        if (a < 12'h200) return "R3 read";
        if (a < 12'h300) return "R4 read";
        if (a >= 12'h400 && a < 12'hC00) return "R5 read";
        if (a >= 12'hC00 && a < 12'hC10) return "R6 read";
        return "R10 read";
    endfunction

    // Applies the effect of the inputs now driven, as the next edge would.
    function automatic void m_step();
        bit v; int id; bit [7:0] p;
        bit [N-1:0] setm, clrm, ackm, eoim, rise, edge_old, wm;
        int w;
        m_pick(v, id, p);
        setm = '0; clrm = '0; ackm = '0; eoim = '0; wm = '0;
        edge_old = m_edge;
        rise = irq_in & ~m_prev;
        if (bus_wr) begin
            w = bus_addr[6:2];
            if (w < 2) wm[w*32 +: 32] = bus_wdata;
            if (bus_addr == 12'h000) m_ctrl = bus_wdata[0];
            else if (bus_addr[11:7] == 5'h02) m_en = m_en | wm;
            else if (bus_addr[11:7] == 5'h03) m_en = m_en & ~wm;
            else if (bus_addr[11:7] == 5'h04) setm = wm;
            else if (bus_addr[11:7] == 5'h05) clrm = wm;
            else if (bus_addr >= 12'h400 && bus_addr < 12'h440) begin
                w = (bus_addr - 12'h400) >> 2;
                for (int k = 0; k < 4; k++) m_prio[4*w + k] = bus_wdata[8*k +: 8];
            end
            else if (bus_addr >= 12'h800 && bus_addr < 12'h840) begin
                w = (bus_addr - 12'h800) >> 2;
                for (int k = 0; k < 4; k++) m_tgt[4*w + k] = bus_wdata[8*k +: 8];
            end
            else if (bus_addr >= 12'hC08 && bus_addr < 12'hC10) begin
                w = (bus_addr - 12'hC00) >> 2;
                for (int k = 0; k < 16; k++) m_edge[16*w + k] = bus_wdata[2*k + 1];
            end
        end
        if (ack && v) ackm[id] = 1'b1;
        if (eoi) eoim[eoi_id] = 1'b1;
        m_pend = ((m_pend & ~clrm & ~ackm) | setm | rise) & edge_old;
        m_act  = (m_act & ~eoim) | ackm;
        m_prev = irq_in;
    endfunction

    // Called just after a falling edge with inputs set; checks, then advances.
    task automatic tick();
        bit v; int id; bit [7:0] p;
        #1;
        m_pick(v, id, p);
        chk(sel_valid == v, "R8 valid", 32'(sel_valid), 32'(v));
        if (v) chk({sel_prio, sel_id} == {p, 6'(id)}, "R8 winner",
                   32'({sel_prio, sel_id}), 32'({p, 6'(id)}));
        chk(bus_rdata == m_read(bus_addr), rtag(bus_addr), bus_rdata, m_read(bus_addr));
        m_step();
        @(negedge clk);
    endtask

    task automatic wr(input bit [11:0] a, input bit [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic peek(input bit [11:0] a, input bit [31:0] e, input string tag);
        bus_addr = a;
        #1;
        chk(bus_rdata == e, tag, bus_rdata, e);
        tick();
    endtask

    task automatic see(input bit v, input int id, input string tag);
        #1;
        chk(sel_valid == v, tag, 32'(sel_valid), 32'(v));
        if (v) chk(sel_id == 6'(id), tag, 32'(sel_id), id);
    endtask

    function automatic bit [11:0] rand_addr();
        case ($urandom % 11)
            0: return 12'h000;
            1: return 12'h004;
            2: return 12'(12'h100 + 4 * ($urandom % 3));
            3: return 12'(12'h180 + 4 * ($urandom % 3));
            4: return 12'(12'h200 + 4 * ($urandom % 3));
            5: return 12'(12'h280 + 4 * ($urandom % 3));
            6: return 12'(12'h400 + 4 * ($urandom % 17));
            7: return 12'(12'h800 + 4 * ($urandom % 17));
            8: return 12'(12'hC00 + 4 * ($urandom % 5));
            9: return 12'h008;
            default: return 12'hFFC;
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7));
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state, R2 type word
        see(0, 0, "R11 no winner after reset");
        peek(12'h000, 32'h0, "R11 control");
        peek(12'hC00, 32'hAAAAAAAA, "R11 low IDs edge");
        peek(12'hC08, 32'h0, "R11 shared IDs level");
        peek(12'h004, 32'h1, "R2 type word");

        // R3 write-one enable windows
        wr(12'h104, 32'h300);
        peek(12'h104, 32'h300, "R3 set window");
        peek(12'h184, 32'h300, "R3 clear window reads state");
        wr(12'h184, 32'h100);
        peek(12'h104, 32'h200, "R3 clear one bit");
        wr(12'h104, 32'h100);
        wr(12'h104, 32'h0);
        peek(12'h104, 32'h300, "R3 zero has no effect");

        // R5 priority and target packing
        wr(12'h428, 32'h0505);
        peek(12'h428, 32'h0505, "R5 priority bytes");
        wr(12'h828, 32'h01020304);
        peek(12'h828, 32'h01020304, "R5 target bytes");

        // R1 gating, R7 level, R8 order
        irq_in[41] = 1'b1;
        see(0, 0, "R1 blocked while control clear");
        tick();
        wr(12'h000, 32'h1);
        see(1, 41, "R7 level line forwarded");
        irq_in[40] = 1'b1;
        see(1, 40, "R8 tie goes to lower ID");
        tick();
        wr(12'h428, 32'h0305);
        see(1, 41, "R8 lower value wins");
        irq_in[41] = 1'b0;
        see(1, 40, "R7 level follows input");
        tick();

        // R6 trigger config, R7 edge latch
        wr(12'hC08, 32'h1 << 17);
        peek(12'hC08, 32'h1 << 17, "R6 edge bit position");
        see(0, 0, "R7 edge needs a rise");
        irq_in[40] = 1'b0;
        tick();
        irq_in[40] = 1'b1;
        see(0, 0, "R7 edge not pending in rise cycle");
        tick();
        see(1, 40, "R7 edge pending after rise");
        irq_in[40] = 1'b0;
        tick();
        see(1, 40, "R7 edge sticky");
        peek(12'h204, 32'h100, "R4 pending read");

        // R9 acknowledge and end-of-interrupt
        ack = 1'b1;
        tick();
        ack = 1'b0;
        see(0, 0, "R9 acked interrupt leaves selection");
        peek(12'h204, 32'h0, "R9 acknowledge clears pending");
        eoi = 1'b1; eoi_id = 6'd40;
        tick();
        eoi = 1'b0;
        wr(12'h204, 32'h100);
        see(1, 40, "R4 software set pending");
        tick();
        wr(12'h284, 32'h100);
        see(0, 0, "R4 software clear pending");
        tick();

        // R6 write to low IDs ignored, R10 holes
        wr(12'hC00, 32'h0);
        peek(12'hC00, 32'hAAAAAAAA, "R6 low IDs stay edge");
        wr(12'h008, 32'hFFFFFFFF);
        peek(12'h008, 32'h0, "R10 hole reads zero");
        peek(12'h108, 32'h0, "R10 beyond enable words");
        peek(12'h300, 32'h0, "R10 unused window");
        peek(12'h000, 32'h1, "R10 control unchanged");

        // Random phase
        for (int i = 0; i < 6000; i++) begin
            if ($urandom % 3 == 0) irq_in[$urandom % N] ^= 1'b1;
            bus_addr = rand_addr();
            bus_wr   = ($urandom % 10) < 4;
            if (bus_addr == 12'h000)                bus_wdata = 32'(($urandom % 4) != 0);
            else if (bus_addr[11:10] == 2'b01)      bus_wdata = $urandom & 32'h03030303;
            else                                    bus_wdata = $urandom;
            ack    = ($urandom % 5) == 0;
            eoi    = ($urandom % 5) == 0;
            eoi_id = 6'($urandom % N);
            tick();
        end
        bus_wr = 1'b0; ack = 1'b0; eoi = 1'b0;
        tick();

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule